// File: doc/BRIEF.md
# Banked Byte Add Execution Unit

This block is the execution slice for two byte-add instructions of a small accumulator machine. One instruction adds an 8-bit immediate to the working register. The other adds the working register to a byte held in data memory. For that second form, one instruction bit chooses whether the sum goes back to the working register or to the memory byte. A second bit chooses how the memory address is built: from a bank-select value, from a fixed access window, or from an index base plus an offset when extended mode is on.

Each instruction takes four clock cycles. The block has a free-running phase counter that steps through decode, read, process and write. In the decode cycle the surrounding core presents the instruction word, the current working register, the bank select value, the extended-mode flag and the index base. In the read cycle the block drives a read request to a synchronous data memory. In the process cycle it takes in the returned byte and forms the sum and the flags. In the write cycle it issues the write strobes. The updated working register and the five status flags are held on registered outputs.

Top module: `bnk_add_unit`

## Requirements
- R1: After a synchronous active-low reset, `phase` is 0 (decode), `w_out` and `flags_out` are 0, and `mem_re`, `mem_we`, `w_we`, `flags_we` and `unsupported` are all low.
- R2: `phase` steps 0 (decode), 1 (read), 2 (process), 3 (write), then back to 0, one step per clock. Instruction inputs are sampled in the clock edge that ends phase 0. `mem_re` is high only in phase 1 and only for the register-add form. The memory returns its byte one cycle after the request.
- R3: An instruction whose bits [15:8] equal 0x0F is the literal add. It adds bits [7:0] to the sampled W, asserts `w_we` in phase 3, and loads the sum into `w_out` at the end of phase 3 (for example, 0x10 + 0x15 gives 0x25).
- R4: An instruction whose bits [15:10] equal 6'b001001 is the register add. Bit 9 is the destination bit, bit 8 is the bank bit and bits [7:0] are the file offset f. It adds W to the byte read from `mem_addr`.
- R5: In the register add, destination bit 0 writes the sum to `w_out` and leaves memory untouched (W 0x17 plus byte 0xC2 gives W 0xD9, and the byte stays 0xC2). Destination bit 1 asserts `mem_we` with the sum on `mem_wdata` at the same address and leaves `w_out` unchanged. `mem_we` and `w_we` are never high together.
- R6: With bank bit 1, `mem_addr` is {bsr, f}.
- R7: With bank bit 0, when the indexed case of R8 does not apply, an f below 0x60 gives address 0x000+f and an f of 0x60 or above gives 0xF00+f.
- R8: With bank bit 0, `ext_en` high and f at most 0x5F, `mem_addr` is `idx_base` + f modulo 4096. With f of 0x60 or above, the access mapping of R7 still applies.
- R9: Both adds update `flags_out`, laid out as bit 4 N, bit 3 OV, bit 2 Z, bit 1 DC, bit 0 C. C is the carry out of bit 7 and DC the carry out of bit 3. Z is set when the 8-bit sum is 0, and N is bit 7 of the sum. OV is set when both addends have the same sign and the sum's sign differs from it.
- R10: `w_we`, `mem_we` and `flags_we` are high only in phase 3. `w_out` and `flags_out` change only at the edge that ends a phase 3 with the matching strobe high.
- R11: Any other instruction word raises `unsupported` in phases 1 to 3. It causes no memory read or write and leaves `w_out` and `flags_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| w_in | input | 8 | Current working register, sampled at the end of phase 0 |
| bsr | input | 4 | Bank select value, used when the bank bit is 1 |
| ext_en | input | 1 | Extended mode enable for indexed offset addressing |
| idx_base | input | 12 | Index base for the indexed offset address |
| mem_rdata | input | 8 | Read data from the synchronous memory, valid in phase 2 |
| phase | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |
| mem_addr | output | 12 | Data memory address for the current instruction |
| mem_re | output | 1 | Memory read request (phase 1) |
| mem_we | output | 1 | Memory write strobe (phase 3) |
| mem_wdata | output | 8 | Sum to be written to memory |
| w_out | output | 8 | Registered updated working register |
| w_we | output | 1 | Working register write strobe (phase 3) |
| flags_out | output | 5 | Registered flags {N, OV, Z, DC, C} |
| flags_we | output | 1 | Flag write strobe (phase 3) |
| unsupported | output | 1 | Instruction word is neither add form |

## Verification
Some properties are checked on every cycle by the assertions. Write strobes appear only in the write phase, and the two destinations are never written together. The phase counter wraps in order. `w_out` and `flags_out` hold whenever their strobe is low. An unsupported word produces no strobe, and an access-window address always lands on page 0x0 or page 0xF. Other behaviour can only be shown by the bench scenarios, which compare against values computed arithmetically. These cover the sum and the five flag values across swept operands. They also cover which of the bank, access and indexed paths produced the address, index wrap-around, and whether memory really kept or took the byte.

// File: rtl/bnk_add_pkg.sv
// Package bnk_add_pkg
// Shared types and constants for the banked byte add unit.
// Assumes an 8-bit data path and a 16-bit instruction word.
package bnk_add_pkg;

    localparam int DW     = 8;
    localparam int IW     = 16;
    localparam int FLAG_W = 5;

    // Bit positions inside the flag vector
    localparam int FL_C  = 0;
    localparam int FL_DC = 1;
    localparam int FL_Z  = 2;
    localparam int FL_OV = 3;
    localparam int FL_N  = 4;

    typedef enum logic [1:0] {
        PH_DEC  = 2'd0,
        PH_RD   = 2'd1,
        PH_PROC = 2'd2,
        PH_WR   = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        OPK_IDLE = 2'd0,
        OPK_LIT  = 2'd1,
        OPK_REG  = 2'd2,
        OPK_BAD  = 2'd3
    } opk_t;

    typedef struct packed {
        opk_t          kind;
        logic          dest_f;
        logic          banked;
        logic [DW-1:0] operand;
    } dec_t;

endpackage

// File: rtl/bnk_add_decode.sv
// Module bnk_add_decode
// Sorts an instruction word into literal add, register add or
// unsupported, and splits out the destination bit, the bank bit and
// the 8-bit operand field. Purely combinational.
module bnk_add_decode
    import bnk_add_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    localparam logic [7:0] LIT_OPC = 8'h0F;
    localparam logic [5:0] REG_OPC = 6'b001001;

    // Classify the opcode and extract the fields
    always_comb begin
        dec.operand = instr[DW-1:0];
        dec.banked  = instr[8];
        dec.dest_f  = instr[9];
        if (instr[IW-1:8] == LIT_OPC)
            dec.kind = OPK_LIT;
        else if (instr[IW-1:10] == REG_OPC)
            dec.kind = OPK_REG;
        else
            dec.kind = OPK_BAD;
    end

endmodule

// File: rtl/bnk_add_agen.sv
// Module bnk_add_agen
// Forms the data memory address from the file offset. The three cases
// are bank-select plus offset, the access window split at ACC_SPLIT,
// and index base plus offset in extended mode. Assumes AW > DW.
module bnk_add_agen #(
    parameter int             DW        = 8,
    parameter int             AW        = 12,
    parameter logic [DW-1:0]  ACC_SPLIT = 8'h60
) (
    input  logic [DW-1:0]    f,
    input  logic             banked,
    input  logic             ext_en,
    input  logic [AW-DW-1:0] bsr,
    input  logic [AW-1:0]    idx,
    output logic [AW-1:0]    addr,
    output logic             indexed
);

    localparam int             HW       = AW - DW;
    localparam logic [HW-1:0]  LOW_PAGE = '0;
    localparam logic [HW-1:0]  TOP_PAGE = '1;

    // Choose between the banked, indexed and access window addresses
    always_comb begin
        indexed = !banked && ext_en && (f < ACC_SPLIT);
        if (banked)
            addr = {bsr, f};
        else if (indexed)
            addr = idx + {LOW_PAGE, f};
        else if (f < ACC_SPLIT)
            addr = {LOW_PAGE, f};
        else
            addr = {TOP_PAGE, f};
    end

endmodule

// File: rtl/bnk_add_alu.sv
// Module bnk_add_alu
// Adds two DW-bit operands. Produces the sum plus carry, half carry,
// zero, negative and signed overflow flags. Assumes DW is even.
module bnk_add_alu
    import bnk_add_pkg::*;
#(
    parameter int ADW = 8
) (
    input  logic [ADW-1:0]    a,
    input  logic [ADW-1:0]    b,
    output logic [ADW-1:0]    res,
    output logic [FLAG_W-1:0] flags
);

    localparam int NW = ADW / 2;

    logic [ADW:0] full;
    logic [NW:0]  low;

    // Full-width and low-half sums
    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
    end

    // Result and flag derivation
    always_comb begin
        res          = full[ADW-1:0];
        flags[FL_C]  = full[ADW];
        flags[FL_DC] = low[NW];
        flags[FL_Z]  = ~|full[ADW-1:0];
        flags[FL_N]  = full[ADW-1];
        flags[FL_OV] = (a[ADW-1] == b[ADW-1]) && (full[ADW-1] != a[ADW-1]);
    end

endmodule

// File: rtl/bnk_add_unit.sv
// Module bnk_add_unit
// Four-phase execution unit for the literal add and register add.
// Phase 0 samples the instruction inputs, phase 1 reads memory,
// phase 2 forms the sum and flags, and phase 3 issues the write strobes.
// Assumes a synchronous memory that returns data one cycle after mem_re.
module bnk_add_unit
    import bnk_add_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr,
    input  logic [DW-1:0]     w_in,
    input  logic [AW-DW-1:0]  bsr,
    input  logic              ext_en,
    input  logic [AW-1:0]     idx_base,
    input  logic [DW-1:0]     mem_rdata,
    output logic [1:0]        phase,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     w_out,
    output logic              w_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic              flags_we,
    output logic              unsupported
);

    localparam int BW = AW - DW;

    phase_t            phase_q;
    dec_t              dec_now;
    dec_t              dec_q;
    logic [DW-1:0]     w_lat;
    logic [BW-1:0]     bsr_q;
    logic              ext_q;
    logic [AW-1:0]     idx_q;
    logic [DW-1:0]     b_opnd;
    logic [DW-1:0]     alu_res;
    logic [FLAG_W-1:0] alu_flags;
    logic [DW-1:0]     res_q;
    logic [FLAG_W-1:0] flg_pend;
    logic [DW-1:0]     w_out_q;
    logic [FLAG_W-1:0] flags_q;
    logic              is_add;
    logic              indexed;

    bnk_add_decode u_decode (
        .instr (instr),
        .dec   (dec_now)
    );

    bnk_add_agen #(
        .DW        (DW),
        .AW        (AW),
        .ACC_SPLIT (8'h60)
    ) u_agen (
        .f       (dec_q.operand),
        .banked  (dec_q.banked),
        .ext_en  (ext_q),
        .bsr     (bsr_q),
        .idx     (idx_q),
        .addr    (mem_addr),
        .indexed (indexed)
    );

    // Second addend: the memory byte for the register add, else the literal
    always_comb b_opnd = (dec_q.kind == OPK_REG) ? mem_rdata : dec_q.operand;

    bnk_add_alu #(
        .ADW (DW)
    ) u_alu (
        .a     (w_lat),
        .b     (b_opnd),
        .res   (alu_res),
        .flags (alu_flags)
    );

    // Free-running phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_DEC;
        else        phase_q <= phase_t'(phase_q + 2'd1);
    end

    // Sample instruction and context inputs at the end of decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
            w_lat <= '0;
            bsr_q <= '0;
            ext_q <= 1'b0;
            idx_q <= '0;
        end else if (phase_q == PH_DEC) begin
            dec_q <= dec_now;
            w_lat <= w_in;
            bsr_q <= bsr;
            ext_q <= ext_en;
            idx_q <= idx_base;
        end
    end

    // Hold the sum and flags formed in the process phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            flg_pend <= '0;
        end else if (phase_q == PH_PROC) begin
            res_q    <= alu_res;
            flg_pend <= alu_flags;
        end
    end

    // Architectural W and flag registers, updated at the end of write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_out_q <= '0;
            flags_q <= '0;
        end else begin
            if (w_we)     w_out_q <= res_q;
            if (flags_we) flags_q <= flg_pend;
        end
    end

    // Strobes and status outputs
    always_comb begin
        is_add      = (dec_q.kind == OPK_LIT) || (dec_q.kind == OPK_REG);
        phase       = phase_q;
        mem_re      = (phase_q == PH_RD) && (dec_q.kind == OPK_REG);
        mem_we      = (phase_q == PH_WR) && (dec_q.kind == OPK_REG) && dec_q.dest_f;
        w_we        = (phase_q == PH_WR) &&
                      ((dec_q.kind == OPK_LIT) || ((dec_q.kind == OPK_REG) && !dec_q.dest_f));
        flags_we    = (phase_q == PH_WR) && is_add;
        unsupported = (dec_q.kind == OPK_BAD) && (phase_q != PH_DEC);
        mem_wdata   = res_q;
        w_out       = w_out_q;
        flags_out   = flags_q;
    end

    // Write strobes are confined to the write phase
    assert_strobe_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || w_we || flags_we) |-> (phase == 2'd3));

    // W and flags hold when not strobed
    assert_wout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !w_we |=> $stable(w_out));
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(flags_out));

    // Exactly one destination per register add
    assert_dest_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && w_we));

    // Phase ordering wraps from write back to decode
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> (phase == 2'd0));
    assert_read_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (phase == 2'd1));

    // Unsupported words cause no side effects
    assert_bad_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> !(mem_we || w_we || flags_we || mem_re));

    // Access-window reads land on the low page or the top page
    assert_access_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !dec_q.banked && !indexed) |->
            ((mem_addr[AW-1:DW] == '0) || (mem_addr[AW-1:DW] == '1)));

endmodule

// File: tb/bnk_add_unit_bench.sv
`timescale 1ns/1ps
module bnk_add_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  w_in = 8'h00;
    logic [3:0]  bsr = 4'h0;
    logic        ext_en = 1'b0;
    logic [11:0] idx_base = 12'h000;
    logic [7:0]  mem_rdata;
    logic [1:0]  phase;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we, w_we, flags_we, unsupported;
    logic [7:0]  mem_wdata, w_out;
    logic [4:0]  flags_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] mem [4096];

    always #2.5 clk = ~clk;

    bnk_add_unit u_bnk_add_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .w_in(w_in), .bsr(bsr),
        .ext_en(ext_en), .idx_base(idx_base), .mem_rdata(mem_rdata),
        .phase(phase), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .w_out(w_out), .w_we(w_we),
        .flags_out(flags_out), .flags_we(flags_we), .unsupported(unsupported)
    );

    // Synchronous memory model
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R2 watchdog: cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Run one instruction from a decode-phase negedge to the next
    task automatic run(input logic [15:0] ins, input logic [7:0] w, input logic [3:0] b,
                       input logic e, input logic [11:0] ix);
        bit lit, rg, bad, d, a, idxd;
        logic [7:0] f, v, old_b, old_w, sum;
        logic [4:0] old_fl, efl;
        logic [11:0] ea;
        int s, sw, sv, ss;
        string atag;
        lit = (ins[15:8] == 8'h0F);
        rg  = !lit && (ins[15:10] == 6'b001001);
        bad = !lit && !rg;
        d = ins[9]; a = ins[8]; f = ins[7:0];
        idxd = !a && e && (f <= 8'h5F);
        if (a)         begin ea = {b, f};                 atag = "R6"; end
        else if (idxd) begin ea = ix + 12'(f);            atag = "R8"; end
        else           begin ea = (f < 8'h60) ? {4'h0, f} : {4'hF, f}; atag = "R7"; end
        v = lit ? f : mem[ea];
        old_b = mem[ea]; old_w = w_out; old_fl = flags_out;
        s = int'(w) + int'(v);
        sum = s[7:0];
        sw = (w > 127) ? int'(w) - 256 : int'(w);
        sv = (v > 127) ? int'(v) - 256 : int'(v);
        ss = sw + sv;
        efl[4] = sum[7];
        efl[3] = (ss > 127) || (ss < -128);
        efl[2] = (sum == 8'h00);
        efl[1] = ((int'(w) % 16) + (int'(v) % 16)) > 15;
        efl[0] = s > 255;
        instr = ins; w_in = w; bsr = b; ext_en = e; idx_base = ix;
        @(posedge clk); @(negedge clk);
        chk("R2", "read phase", phase, 1);
        chk("R2", "read request", mem_re, rg);
        if (rg) chk(atag, "address", mem_addr, ea);
        chk("R11", "unsupported", unsupported, bad);
        @(posedge clk); @(negedge clk);
        chk("R10", "strobes in process", {mem_we, w_we, flags_we}, 0);
        @(posedge clk); @(negedge clk);
        chk("R5", "mem_we", mem_we, rg && d);
        chk("R3", "w_we", w_we, lit || (rg && !d));
        chk("R9", "flags_we", flags_we, !bad);
        if (rg && d) chk("R5", "mem_wdata", mem_wdata, sum);
        @(posedge clk); @(negedge clk);
        chk("R2", "back to decode", phase, 0);
        if (bad) begin
            chk("R11", "w kept", w_out, old_w);
            chk("R11", "flags kept", flags_out, old_fl);
            chk("R11", "mem kept", mem[ea], old_b);
        end else begin
            chk("R9", "flags", flags_out, efl);
            if (lit)    chk("R3", "w sum", w_out, sum);
            else if (d) begin
                chk("R5", "w kept", w_out, old_w);
                chk("R4", "mem sum", mem[ea], sum);
            end else begin
                chk("R4", "w sum", w_out, sum);
                chk("R5", "mem kept", mem[ea], old_b);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "phase", phase, 0);
        chk("R1", "w_out", w_out, 0);
        chk("R1", "flags_out", flags_out, 0);
        chk("R1", "strobes", {mem_re, mem_we, w_we, flags_we, unsupported}, 0);
        rst_n = 1'b1;
        // Worked examples
        run(16'h0F15, 8'h10, 4'h0, 1'b0, 12'h000);
        chk("R3", "literal example", w_out, 8'h25);
        mem[12'h020] = 8'hC2;
        run(16'h2420, 8'h17, 4'h0, 1'b0, 12'h000);
        chk("R5", "register example W", w_out, 8'hD9);
        chk("R5", "register example mem", mem[12'h020], 8'hC2);
        // Literal add sweep
        for (int w = 0; w < 256; w++)
            for (int k = 0; k < 256; k += 15)
                run({8'h0F, 8'(k)}, 8'(w), 4'h0, 1'b0, 12'h000);
        // Register add sweep over bank/access/indexed paths and both destinations
        for (int p = 0; p < 4; p++)
            for (int w = 0; w < 256; w++) begin
                logic [7:0] wv, fv;
                wv = 8'(w);
                fv = 8'(w * 7 + p * 61 + 3);
                run({6'b001001, wv[1] ^ p[0], wv[0] ^ p[1], fv}, 8'(w * 3 + p),
                    wv[7:4], wv[2], {wv, 4'(p * 5 + 3)});
            end
        // R8 index wrap and extended mode above the split
        run(16'h2420, 8'h01, 4'h0, 1'b1, 12'hFF0);
        run(16'h24A0, 8'h01, 4'h0, 1'b1, 12'h100);
        // R11 unsupported words
        run(16'h0E55, 8'h33, 4'h1, 1'b0, 12'h000);
        run(16'h2855, 8'h33, 4'h1, 1'b0, 12'h000);
        run(16'h0000, 8'h80, 4'h0, 1'b0, 12'h000);
        run(16'hFFFF, 8'hFF, 4'hF, 1'b1, 12'hFFF);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule